// File: doc/BRIEF.md
# Counter-Gated Conditional Branch Resolver

This block resolves one conditional branch per request. It looks at a 5-bit branch-options field, a bit chosen from the 32-bit condition register, and a 64-bit loop count. From these it decides whether the branch is taken, works out the next instruction address and produces the updated count value. It also passes through a request to update the link register. The outputs are registered and appear one clock after the request, with a valid strobe.

The count can be decremented before the loop test. The loop test itself always looks at the count as it was on entry, not at the decremented value. A counter-test mode lets the condition outcome cancel the decrement. In 32-bit addressing mode, only the low word of the count takes part in the zero test, and the upper half of the produced address is cleared. The decrement itself is always a full 64-bit operation that wraps.

Top module: `branch_resolve_unit`

## Requirements
- R1: While reset is held, and until the first request, `resValid`, `taken`, `nextAddr`, `countOut` and `linkOut` are all zero.
- R2: `resValid` is high exactly one cycle after a cycle with `reqValid` high. On a cycle without a request, `taken`, `nextAddr`, `countOut` and `linkOut` keep their values.
- R3: Option bits are numbered MSB-first, so option bit k is `opts[4-k]`. The counter test passes when option bit 2 (`opts[2]`) is 1, or when (selected count bits nonzero) XOR option bit 3 (`opts[1]`) is 1. It uses the count value before any decrement.
- R4: The selected condition bit is `condReg[31-condIdx]`. The condition test passes when option bit 0 (`opts[4]`) is 1, or when that bit equals option bit 1 (`opts[3]`).
- R5: `taken` is 1 only when both the counter test and the condition test pass.
- R6: When `opts[2]` is 0 (and the decrement is not cancelled), `countOut` is `countIn` minus 1, modulo 2^64. When `opts[2]` is 1, `countOut` equals `countIn`.
- R7: When `ctrTestEn` is 1 and (condition test result XOR `invFlag`) is 1, the decrement is cancelled and `countOut` equals `countIn`.
- R8: A taken branch with `absAddr` = 1 yields `nextAddr` = sign-extended {`disp`, 2'b00}.
- R9: A taken branch with `absAddr` = 0 yields `nextAddr` = `curAddr` + sign-extended {`disp`, 2'b00}, modulo 2^64.
- R10: A branch that is not taken yields `nextAddr` = `curAddr` + 4.
- R11: With `wideMode` = 0, the zero test covers only `countIn[31:0]`, and `nextAddr[63:32]` is zero. With `wideMode` = 1, the zero test covers all 64 bits.
- R12: `linkOut` equals the `linkReq` value of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Resolve request this cycle |
| opts | input | 5 | Branch-options field, MSB-first numbering |
| condIdx | input | 5 | Condition-bit index, MSB-first |
| condReg | input | 32 | Condition register |
| countIn | input | 64 | Count register before this branch |
| wideMode | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| ctrTestEn | input | 1 | Lets the condition outcome cancel the decrement |
| invFlag | input | 1 | Inversion flag compared with the condition outcome |
| absAddr | input | 1 | 1 = absolute target, 0 = relative target |
| disp | input | 14 | Word displacement |
| curAddr | input | 64 | Address of the branch |
| linkReq | input | 1 | Link-register update request |
| resValid | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| nextAddr | output | 64 | Next instruction address |
| countOut | output | 64 | Updated count register |
| linkOut | output | 1 | Link-register update flag |

## Verification
A wrong decision or a wrong decrement shows up in the very next cycle: `taken`, `nextAddr` or `countOut` differs from the reference for that request. A fault that holds registers when no request is present shows as a value drifting during idle cycles. The riskiest cases get directed stimulus. One is a count of exactly 1 or 0, where testing the pre-decrement value instead of the post-decrement value flips the outcome. Another is a count whose only set bits lie in the upper word while in 32-bit mode. A third is cancellation of the decrement under each combination of condition outcome and inversion flag.

// File: rtl/brr_pkg.sv
package brr_pkg;
  typedef struct packed {
    logic load;
    logic decCount;
    logic takeBranch;
  } brrStrobes_t;
endpackage

// File: rtl/brr_ctrl.sv
module brr_ctrl
  import brr_pkg::*;
#(
  parameter int OPT_W = 5
) (
  input  logic             reqValid,
  input  logic [OPT_W-1:0] opts,
  input  logic             condBit,
  input  logic             countNonZero,
  input  logic             ctrTestEn,
  input  logic             invFlag,
  output brrStrobes_t      strobes
);
  // option bit k lives at opts[OPT_W-1-k]
  localparam int IgnoreCondPos = OPT_W - 1;
  localparam int CondSensePos  = OPT_W - 2;
  localparam int NoCountPos    = OPT_W - 3;
  localparam int ZeroSensePos  = OPT_W - 4;

  logic ignoreCond, condSense, noCount, zeroSense;
  logic condOk, ctrOk, cancelDec;
  logic unusedHint;

  assign ignoreCond = opts[IgnoreCondPos];
  assign condSense  = opts[CondSensePos];
  assign noCount    = opts[NoCountPos];
  assign zeroSense  = opts[ZeroSensePos];
  assign unusedHint = ^opts[ZeroSensePos-1:0];

  assign condOk    = ignoreCond | ~(condBit ^ condSense);
  assign ctrOk     = noCount | (countNonZero ^ zeroSense);
  assign cancelDec = ctrTestEn & (condOk ^ invFlag);

  always_comb begin
    strobes.load       = reqValid;
    strobes.decCount   = ~noCount & ~cancelDec;
    strobes.takeBranch = ctrOk & condOk;
  end
endmodule

// File: rtl/brr_datapath.sv
module brr_datapath
  import brr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CR_W   = 32,
  parameter int DISP_W = 14
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  brrStrobes_t             strobes,
  input  logic [$clog2(CR_W)-1:0] condIdx,
  input  logic [CR_W-1:0]         condReg,
  input  logic [ADDR_W-1:0]       countIn,
  input  logic                    wideMode,
  input  logic                    absAddr,
  input  logic [DISP_W-1:0]       disp,
  input  logic [ADDR_W-1:0]       curAddr,
  input  logic                    linkReq,
  output logic                    condBit,
  output logic                    countNonZero,
  output logic                    resValid,
  output logic                    taken,
  output logic [ADDR_W-1:0]       nextAddr,
  output logic [ADDR_W-1:0]       countOut,
  output logic                    linkOut
);
  localparam int IDX_W  = $clog2(CR_W);
  localparam int HALF_W = ADDR_W / 2;
  localparam int EXT_W  = ADDR_W - DISP_W - 2;

  logic [IDX_W-1:0]  crPos;
  logic [ADDR_W-1:0] offExt, target, seqAddr, pick, addrNext, countNext;

  assign crPos   = IDX_W'(CR_W - 1) - condIdx;
  assign condBit = condReg[crPos];

  assign countNonZero = wideMode ? (|countIn) : (|countIn[HALF_W-1:0]);

  assign offExt  = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
  assign target  = absAddr ? offExt : curAddr + offExt;
  assign seqAddr = curAddr + ADDR_W'(4);
  assign pick    = strobes.takeBranch ? target : seqAddr;

  always_comb begin
    addrNext = pick;
    if (!wideMode) addrNext[ADDR_W-1:HALF_W] = '0;
  end

  assign countNext = strobes.decCount ? countIn - ADDR_W'(1) : countIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      taken    <= 1'b0;
      nextAddr <= '0;
      countOut <= '0;
      linkOut  <= 1'b0;
    end else begin
      resValid <= strobes.load;
      if (strobes.load) begin
        taken    <= strobes.takeBranch;
        nextAddr <= addrNext;
        countOut <= countNext;
        linkOut  <= linkReq;
      end
    end
  end
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import brr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CR_W   = 32,
  parameter int DISP_W = 14,
  parameter int OPT_W  = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [OPT_W-1:0]        opts,
  input  logic [$clog2(CR_W)-1:0] condIdx,
  input  logic [CR_W-1:0]         condReg,
  input  logic [ADDR_W-1:0]       countIn,
  input  logic                    wideMode,
  input  logic                    ctrTestEn,
  input  logic                    invFlag,
  input  logic                    absAddr,
  input  logic [DISP_W-1:0]       disp,
  input  logic [ADDR_W-1:0]       curAddr,
  input  logic                    linkReq,
  output logic                    resValid,
  output logic                    taken,
  output logic [ADDR_W-1:0]       nextAddr,
  output logic [ADDR_W-1:0]       countOut,
  output logic                    linkOut
);
  brrStrobes_t strobes;
  logic condBit, countNonZero;

  brr_ctrl #(.OPT_W(OPT_W)) ctrl (
    .reqValid(reqValid), .opts(opts), .condBit(condBit),
    .countNonZero(countNonZero), .ctrTestEn(ctrTestEn),
    .invFlag(invFlag), .strobes(strobes)
  );

  brr_datapath #(.ADDR_W(ADDR_W), .CR_W(CR_W), .DISP_W(DISP_W)) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .condIdx(condIdx),
    .condReg(condReg), .countIn(countIn), .wideMode(wideMode),
    .absAddr(absAddr), .disp(disp), .curAddr(curAddr), .linkReq(linkReq),
    .condBit(condBit), .countNonZero(countNonZero), .resValid(resValid),
    .taken(taken), .nextAddr(nextAddr), .countOut(countOut), .linkOut(linkOut)
  );
endmodule

// File: rtl/brr_checker.sv
module brr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [4:0]  opts,
  input logic [63:0] countIn,
  input logic        wideMode,
  input logic [63:0] curAddr,
  input logic        linkReq,
  input logic        resValid,
  input logic        taken,
  input logic [63:0] nextAddr,
  input logic [63:0] countOut,
  input logic        linkOut
);
  logic [63:0] seqRaw, seqExp;
  assign seqRaw = curAddr + 64'd4;
  assign seqExp = wideMode ? seqRaw : {32'd0, seqRaw[31:0]};

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resValid);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!resValid && $stable(nextAddr) && $stable(countOut) && $stable(taken)));
  // R6
  no_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opts[2]) |=> countOut == $past(countIn));
  // R6
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !opts[2]) |=> (countOut == $past(countIn) || countOut == $past(countIn) - 64'd1));
  // R10
  seq_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (taken || nextAddr == $past(seqExp)));
  // R11
  narrow_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !wideMode) |=> nextAddr[63:32] == 32'd0);
  // R5
  zero_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && wideMode && !opts[2] && !opts[1] && countIn == 64'd0) |=> !taken);
  // R12
  link_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> linkOut == $past(linkReq));
endmodule

bind branch_resolve_unit brr_checker chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .opts(opts),
  .countIn(countIn), .wideMode(wideMode), .curAddr(curAddr),
  .linkReq(linkReq), .resValid(resValid), .taken(taken),
  .nextAddr(nextAddr), .countOut(countOut), .linkOut(linkOut)
);

// File: tb/branch_resolve_unit_test.sv
`timescale 1ns/1ps
module branch_resolve_unit_test;
  logic clk = 0;
  logic rstN = 0;
  logic reqValid = 0;
  logic [4:0] opts = 0;
  logic [4:0] condIdx = 0;
  logic [31:0] condReg = 0;
  logic [63:0] countIn = 0;
  logic wideMode = 0, ctrTestEn = 0, invFlag = 0, absAddr = 0, linkReq = 0;
  logic [13:0] disp = 0;
  logic [63:0] curAddr = 0;
  logic resValid, taken, linkOut;
  logic [63:0] nextAddr, countOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // expected state of the outputs
  bit eValid = 0, eTaken = 0, eLink = 0;
  logic [63:0] eNext = 0, eCount = 0;

  always #2.5 clk = ~clk;

  branch_resolve_unit uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opts(opts), .condIdx(condIdx),
    .condReg(condReg), .countIn(countIn), .wideMode(wideMode),
    .ctrTestEn(ctrTestEn), .invFlag(invFlag), .absAddr(absAddr), .disp(disp),
    .curAddr(curAddr), .linkReq(linkReq), .resValid(resValid), .taken(taken),
    .nextAddr(nextAddr), .countOut(countOut), .linkOut(linkOut)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    chk(tag, "resValid", 64'(resValid), 64'(eValid));
    chk(tag, "taken", 64'(taken), 64'(eTaken));
    chk(tag, "nextAddr", nextAddr, eNext);
    chk(tag, "countOut", countOut, eCount);
    chk(tag, "linkOut", 64'(linkOut), 64'(eLink));
  endtask

  // behavioural reference: option bit k is opts[4-k]
  task automatic modelStep(bit req, logic [4:0] o, int idx, logic [31:0] cr,
                           logic [63:0] cnt, bit wide, bit cte, bit inv,
                           bit abs, logic [13:0] d, logic [63:0] pc, bit lk);
    bit crBit, cOk, zOk, willDec, tk;
    bit nz;
    longint off;
    logic [63:0] nx;
    eValid = req;
    if (!req) return;
    crBit = cr[31 - idx];
    cOk = o[4] ? 1'b1 : (crBit == o[3]);
    nz = wide ? (cnt != 0) : (cnt[31:0] != 0);
    zOk = o[2] ? 1'b1 : (nz != o[1]);
    tk = cOk && zOk;
    willDec = !o[2];
    if (cte && (cOk != inv)) willDec = 0;
    off = longint'($signed(d)) * 4;
    if (tk) nx = abs ? 64'(off) : pc + 64'(off);
    else nx = pc + 64'd4;
    if (!wide) nx = nx & 64'h0000_0000_FFFF_FFFF;
    eTaken = tk;
    eNext = nx;
    eCount = willDec ? cnt - 64'd1 : cnt;
    eLink = lk;
  endtask

  // compare the previous cycle's result, then present the next request
  task automatic step(string tag, bit req, logic [4:0] o, int idx, logic [31:0] cr,
                      logic [63:0] cnt, bit wide, bit cte, bit inv, bit abs,
                      logic [13:0] d, logic [63:0] pc, bit lk);
    @(negedge clk);
    compareAll(tag);
    modelStep(req, o, idx, cr, cnt, wide, cte, inv, abs, d, pc, lk);
    reqValid = req; opts = o; condIdx = 5'(idx); condReg = cr; countIn = cnt;
    wideMode = wide; ctrTestEn = cte; invFlag = inv; absAddr = abs;
    disp = d; curAddr = pc; linkReq = lk;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R1");
    @(negedge clk);
    rstN = 1;
    step("R1", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    // R4: condition bit index 0 is condReg[31]; always-taken counter path
    step("R1", 1, 5'b01100, 0, 32'h8000_0000, 64'd7, 1, 0, 0, 0, 14'd16, 64'h1000, 1);
    step("R4", 1, 5'b01100, 31, 32'h8000_0000, 64'd7, 1, 0, 0, 0, 14'd16, 64'h1000, 0);
    step("R4", 1, 5'b00100, 31, 32'h0000_0000, 64'd7, 1, 0, 0, 0, 14'd16, 64'h1000, 1);
    step("R4", 1, 5'b10100, 5, 32'h0, 64'd3, 1, 0, 0, 0, 14'h3FFF, 64'h2000, 0);
    // R3: count 1 with nonzero sense -> taken (pre-decrement test)
    step("R4", 1, 5'b10000, 0, 0, 64'd1, 1, 0, 0, 0, 14'd8, 64'h3000, 0);
    // R3: count 0 with zero sense -> taken, wrap to all ones (R6)
    step("R3", 1, 5'b10010, 0, 0, 64'd0, 1, 0, 0, 0, 14'd8, 64'h3000, 0);
    step("R6", 1, 5'b10000, 0, 0, 64'd0, 1, 0, 0, 0, 14'd8, 64'h3000, 0);
    // R11: upper-word-only count in narrow vs wide mode
    step("R6", 1, 5'b10000, 0, 0, 64'h1_0000_0000, 0, 0, 0, 0, 14'd4, 64'hFFFF_FFFF_FFFF_FFF0, 0);
    step("R11", 1, 5'b10000, 0, 0, 64'h1_0000_0000, 1, 0, 0, 0, 14'd4, 64'hFFFF_FFFF_FFFF_FFF0, 0);
    step("R11", 1, 5'b10010, 0, 0, 64'h1_0000_0000, 0, 0, 0, 0, 14'd4, 64'hFFFF_FFFF_FFFF_FFF0, 0);
    // R7: decrement cancelled vs kept under counter-test mode
    step("R11", 1, 5'b10000, 0, 0, 64'd9, 1, 1, 0, 0, 14'd2, 64'h4000, 0);
    step("R7", 1, 5'b10000, 0, 0, 64'd9, 1, 1, 1, 0, 14'd2, 64'h4000, 0);
    step("R7", 1, 5'b00000, 3, 32'h0000_0000, 64'd9, 1, 1, 1, 0, 14'd2, 64'h4000, 0);
    step("R7", 1, 5'b00000, 3, 32'h1000_0000, 64'd9, 1, 1, 1, 0, 14'd2, 64'h4000, 0);
    // R8 and R9: absolute and relative, negative displacement
    step("R7", 1, 5'b10100, 0, 0, 64'd5, 1, 0, 0, 1, 14'h2000, 64'h5000, 0);
    step("R8", 1, 5'b10100, 0, 0, 64'd5, 1, 0, 0, 1, 14'h0123, 64'h5000, 0);
    step("R8", 1, 5'b10100, 0, 0, 64'd5, 1, 0, 0, 0, 14'h3FF0, 64'h5000, 0);
    step("R9", 1, 5'b10100, 0, 0, 64'd5, 0, 0, 0, 0, 14'h0010, 64'hABCD_FFFF_FFF0, 0);
    // R10: not taken in both modes
    step("R9", 1, 5'b00100, 0, 32'h8000_0000, 64'd5, 1, 0, 0, 0, 14'h0010, 64'h7FFF_FFFF_FFFF_FFFC, 1);
    step("R10", 1, 5'b00100, 0, 32'h8000_0000, 64'd5, 0, 0, 0, 1, 14'h0010, 64'h1_FFFF_FFFC, 1);
    // R2: idle cycles hold outputs while inputs change
    step("R10", 0, 5'b10100, 0, 0, 64'd77, 1, 0, 0, 1, 14'h0777, 64'h9999, 0);
    step("R2", 0, 5'b00000, 0, 0, 64'd0, 0, 1, 1, 0, 14'h0001, 64'h1, 1);
    step("R2", 1, 5'b10100, 0, 0, 64'd2, 1, 0, 0, 0, 14'h0001, 64'h100, 1);
    // R12 and R5 last compare
    step("R12", 1, 5'b00000, 10, 32'h0020_0000, 64'd1, 1, 0, 0, 0, 14'h0004, 64'h200, 0);
    step("R5", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compareAll("R2");
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule